// File: doc/BRIEF.md
# Length-Framed Request/Response Packet Handler

This block sits between a byte-wide serial receiver and a byte-wide serial transmitter. It assembles incoming bytes into requests whose first byte gives the whole packet length, that byte included. It classifies each finished request and answers it with a fixed reply that is streamed out one byte at a time. Input bytes arrive on a valid/data pair. Output bytes leave on a valid/ready pair, so a slow transmitter can stall the reply at any byte.

Two requests are recognised. The first is a lone zero byte, which acts as a liveness probe and is answered with one byte. The second is an eight-byte query whose message-type byte at offset 3 is zero, and it is answered with a sixteen-byte record. Anything else that completes as a packet is dropped without a reply. There is no checksum. A packet that stops arriving part-way is abandoned after a configurable number of idle cycles. The framer then treats the next byte as a new length byte.

Top module: `pkt_handler`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and in the first cycle after it, `tx_valid` is low.
- R2: A length byte of 0x00 received while no packet is in progress is a complete probe request. It is answered with exactly one byte, 0x01, and `tx_valid` rises in the cycle after that byte is accepted.
- R3: A packet with length byte 0x08 and a type byte of 0x00 at offset 3 is answered with exactly sixteen bytes, in this order: 10 00 00 00 DE AD BE EF 13 37 0D 13 00 00 00 00.
- R4: After a length byte L greater than 1, the block consumes exactly L bytes in total, the length byte included, before it takes the next byte as a new length byte.
- R5: A finished packet that matches neither supported request produces no output byte. This covers a length byte of 0x01 alone, any length other than 0 or 8, and length 8 with a non-zero type byte.
- R6: A reply byte advances only on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value.
- R7: Bytes offered on the receive side while a reply is being sent are ignored. They add no reply, they do not alter the reply in progress, and they do not start a packet.
- R8: When a packet is in progress, a run of up to TIMEOUT_CYC-1 cycles with no received byte keeps the packet going. After TIMEOUT_CYC such cycles the packet is discarded, and the next byte is taken as a new length byte.
- R9: Asserting `rst` during a reply stops it. After reset a new probe is answered normally.
- R10: For the query, bytes at offsets 1, 2 and 4 to 7 are not decoded, so any value there still draws the sixteen-byte reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present on rx_data this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | A reply byte is offered on tx_data |
| tx_ready | input | 1 | The transmitter accepts the offered byte this cycle |
| tx_data | output | 8 | Reply byte |

## Verification
The bench sweeps all 256 type values for an eight-byte packet. Only type 0x00 may draw the long reply. This separates the type decode from the length decode. Lengths 1 to 12, each with type zero except 8, are each followed by a probe. A single pong after each one shows that exactly L bytes were consumed and that nothing was answered. Replies are drained with an always-ready sink and with a periodically stalling sink, so that byte order under back-pressure is checked. Idle gaps of TIMEOUT_CYC-1 and TIMEOUT_CYC cycles mark the timeout boundary. Bytes injected during a reply, nonzero query payloads and a reset in mid-reply cover the remaining requirements.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

    typedef logic [7:0] byte_t;

    localparam int RESP_PONG_LEN = 1;
    localparam int RESP_INFO_LEN = 16;
    localparam int IDX_W         = $clog2(RESP_INFO_LEN);
    localparam int REQ_INFO_LEN  = 8;
    localparam int TYPE_OFS      = 3;
    localparam byte_t TYPE_INFO  = 8'h00;
    localparam byte_t TYPE_NONE  = 8'hFF;
    localparam byte_t PONG_BYTE  = 8'h01;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_PONG = 2'd1,
        RK_INFO = 2'd2
    } rkind_e;

    typedef struct packed {
        logic  done;
        byte_t len;
        byte_t mtype;
    } pkt_s;

    function automatic byte_t info_byte(input logic [IDX_W-1:0] i);
        byte_t b;
        case (i)
            4'd0:    b = 8'h10;
            4'd4:    b = 8'hDE;
            4'd5:    b = 8'hAD;
            4'd6:    b = 8'hBE;
            4'd7:    b = 8'hEF;
            4'd8:    b = 8'h13;
            4'd9:    b = 8'h37;
            4'd10:   b = 8'h0D;
            4'd11:   b = 8'h13;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    function automatic logic [IDX_W-1:0] last_index(input rkind_e k);
        if (k == RK_INFO) return IDX_W'(RESP_INFO_LEN - 1);
        return IDX_W'(RESP_PONG_LEN - 1);
    endfunction

    function automatic byte_t resp_byte(input rkind_e k, input logic [IDX_W-1:0] i);
        if (k == RK_INFO) return info_byte(i);
        return PONG_BYTE;
    endfunction

endpackage

// File: rtl/pkt_framer.sv
module pkt_framer
    import pkt_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  byte_t data,
    output pkt_s  pkt,
    output logic  collecting
);
    localparam int GAP_W = $clog2(TIMEOUT_CYC + 1);

    logic             coll_q;
    byte_t            len_q;
    byte_t            cnt_q;
    byte_t            cnt_n;
    byte_t            type_q;
    logic [GAP_W-1:0] gap_q;
    logic             gap_end;

    assign cnt_n      = 8'(cnt_q + 8'd1);
    assign gap_end    = (gap_q == GAP_W'(TIMEOUT_CYC - 1));
    assign collecting = coll_q;

    always_comb begin
        pkt = '0;
        if (fire) begin
            if (!coll_q) begin
                if (data <= 8'd1) begin
                    pkt.done  = 1'b1;
                    pkt.len   = data;
                    pkt.mtype = TYPE_NONE;
                end
            end else if (cnt_n == len_q) begin
                pkt.done  = 1'b1;
                pkt.len   = len_q;
                pkt.mtype = (cnt_q == 8'(TYPE_OFS)) ? data : type_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coll_q <= 1'b0;
            len_q  <= '0;
            cnt_q  <= '0;
            type_q <= TYPE_NONE;
            gap_q  <= '0;
        end else if (fire) begin
            gap_q <= '0;
            if (!coll_q) begin
                if (data > 8'd1) begin
                    coll_q <= 1'b1;
                    len_q  <= data;
                    cnt_q  <= 8'd1;
                    type_q <= TYPE_NONE;
                end
            end else begin
                if (cnt_q == 8'(TYPE_OFS)) type_q <= data;
                if (cnt_n == len_q) begin
                    coll_q <= 1'b0;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_n;
                end
            end
        end else if (coll_q) begin
            if (gap_end) begin
                coll_q <= 1'b0;
                cnt_q  <= '0;
                gap_q  <= '0;
            end else begin
                gap_q <= GAP_W'(gap_q + 1'b1);
            end
        end
    end

endmodule

// File: rtl/pkt_decoder.sv
module pkt_decoder
    import pkt_pkg::*;
(
    input  pkt_s   pkt,
    output rkind_e kind
);
    always_comb begin
        kind = RK_NONE;
        if (pkt.done) begin
            if (pkt.len == 8'd0)
                kind = RK_PONG;
            else if (pkt.len == 8'(REQ_INFO_LEN) && pkt.mtype == TYPE_INFO)
                kind = RK_INFO;
        end
    end
endmodule

// File: rtl/pkt_responder.sv
module pkt_responder
    import pkt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  rkind_e kind,
    input  logic   tx_ready,
    output logic   tx_valid,
    output byte_t  tx_data,
    output logic   busy
);
    logic             act_q;
    rkind_e           kind_q;
    logic [IDX_W-1:0] idx_q;

    assign tx_valid = act_q;
    assign busy     = act_q;
    assign tx_data  = act_q ? resp_byte(kind_q, idx_q) : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            kind_q <= RK_NONE;
            idx_q  <= '0;
        end else if (!act_q) begin
            if (kind != RK_NONE) begin
                act_q  <= 1'b1;
                kind_q <= kind;
                idx_q  <= '0;
            end
        end else if (tx_ready) begin
            if (idx_q == last_index(kind_q)) begin
                act_q <= 1'b0;
                idx_q <= '0;
            end else begin
                idx_q <= IDX_W'(idx_q + 1'b1);
            end
        end
    end
endmodule

// File: rtl/pkt_handler.sv
module pkt_handler
    import pkt_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic [7:0] tx_data
);
    logic   rx_fire;
    logic   resp_busy;
    logic   frm_collecting;
    pkt_s   frm_pkt;
    rkind_e dec_kind;

    assign rx_fire = rx_valid && !resp_busy;

    pkt_framer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .fire       (rx_fire),
        .data       (rx_data),
        .pkt        (frm_pkt),
        .collecting (frm_collecting)
    );

    pkt_decoder u_decoder (
        .pkt  (frm_pkt),
        .kind (dec_kind)
    );

    pkt_responder u_resp (
        .clk      (clk),
        .rst      (rst),
        .kind     (dec_kind),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .busy     (resp_busy)
    );
endmodule

// File: rtl/pkt_handler_chk.sv
module pkt_handler_chk #(
    parameter int TIMEOUT_CYC = 1000
) (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       collecting,
    input logic       busy
);
    localparam int GAP_W = $clog2(TIMEOUT_CYC + 1);

    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst || !collecting || (rx_valid && !busy)) gap <= '0;
        else if (gap != GAP_W'(TIMEOUT_CYC)) gap <= GAP_W'(gap + 1'b1);
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !tx_valid && !collecting);

    p_pong_next_r2: assert property (@(posedge clk) disable iff (rst)
        (!collecting && !busy && rx_valid && rx_data == 8'h00)
            |=> (tx_valid && tx_data == 8'h01));

    p_first_byte_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_data == 8'h10 || tx_data == 8'h01));

    p_hold_data_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_rx_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !collecting);

    p_gap_bound_r8: assert property (@(posedge clk) disable iff (rst)
        collecting |-> (gap < GAP_W'(TIMEOUT_CYC)));

endmodule

bind pkt_handler pkt_handler_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .collecting (frm_collecting),
    .busy       (resp_busy)
);

// File: tb/pkt_handler_test.sv
module pkt_handler_test;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 8;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_valid;
    logic       tx_ready = 1'b1;
    logic [7:0] tx_data;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int ready_mode = 0;
    bit done_flag = 1'b0;
    logic [7:0] got[$];

    localparam logic [7:0] INFO_EXP [16] = '{8'h10, 8'h00, 8'h00, 8'h00,
        8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h13, 8'h37, 8'h0D, 8'h13,
        8'h00, 8'h00, 8'h00, 8'h00};

    pkt_handler #(.TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        cyc++;
        tx_ready = (ready_mode != 0) ? ((cyc % 3) != 1) : 1'b1;
        if (cyc > WATCHDOG && !done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    always @(negedge clk)
        if (!rst && tx_valid && tx_ready) got.push_back(tx_data);

    task automatic finish_run();
        done_flag = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        step();
        rx_valid = 1'b0; rx_data = 8'h00;
    endtask

    task automatic send_pkt(int len, logic [7:0] mtype, logic [7:0] fill);
        send(8'(len));
        for (int i = 1; i < len; i++) send((i == 3) ? mtype : fill);
    endtask

    // kind: 0 no reply, 1 pong, 2 info
    task automatic expect_resp(string req, int kind);
        int n;
        n = (kind == 2) ? 16 : kind;
        for (int w = 0; w < 200 && got.size() < n; w++) step();
        step(30);
        check({req, " reply length"}, got.size(), n);
        for (int i = 0; i < n && i < got.size(); i++)
            check({req, " reply byte"}, got[i], (kind == 2) ? INFO_EXP[i] : 8'h01);
        got.delete();
    endtask

    initial begin
        step(3);
        check("R1 tx_valid in reset", tx_valid, 0);
        rst = 1'b0;
        check("R1 tx_valid after reset", tx_valid, 0);
        step(2);

        // R2 probe
        send(8'h00);
        check("R2 valid next cycle", tx_valid, 1);
        check("R2 data next cycle", tx_data, 8'h01);
        expect_resp("R2", 1);

        // R3 query, ready always and with stalls (R6)
        send_pkt(8, 8'h00, 8'h00);
        expect_resp("R3", 2);
        ready_mode = 1;
        send_pkt(8, 8'h00, 8'h00);
        expect_resp("R6 stalled R3", 2);
        send(8'h00);
        expect_resp("R6 stalled R2", 1);
        ready_mode = 0;

        // R4/R5 length sweep, each followed by a probe
        for (int l = 1; l <= 12; l++) begin
            if (l == 8) continue;
            send_pkt(l, 8'h00, 8'h00);
            send(8'h00);
            expect_resp("R4 R5 length sweep", 1);
        end

        // R5 type sweep
        for (int t = 0; t < 256; t++) begin
            send_pkt(8, 8'(t), 8'h00);
            expect_resp("R5 type sweep", (t == 0) ? 2 : 0);
        end

        // R10 payload not decoded
        for (int f = 1; f < 256; f += 37) begin
            send_pkt(8, 8'h00, 8'(f));
            expect_resp("R10 payload", 2);
        end

        // R7 bytes during reply ignored
        send_pkt(8, 8'h00, 8'h00);
        step(2);
        send(8'h00); send(8'h08); send(8'h00);
        expect_resp("R7", 2);
        send(8'h00);
        expect_resp("R7 after", 1);

        // R8 timeout boundary
        send(8'h08);
        step(TMO - 1);
        for (int i = 1; i < 8; i++) send(8'h00);
        expect_resp("R8 gap below limit", 2);
        send(8'h08);
        step(TMO);
        send(8'h00);
        expect_resp("R8 gap at limit", 1);

        // R9 reset during reply
        send_pkt(8, 8'h00, 8'h00);
        step(4);
        rst = 1'b1;
        step(2);
        check("R9 tx_valid in reset", tx_valid, 0);
        rst = 1'b0;
        step(1);
        check("R9 tx_valid after reset", tx_valid, 0);
        got.delete();
        send(8'h00);
        expect_resp("R9 probe after reset", 1);

        finish_run();
    end
endmodule